// File: doc/BRIEF.md
# Serial Control Register Loader

This block is a write-only serial slave that fills a small bank of 12-bit control registers from three pins: a serial clock, a serial data line and an active-low load strobe. The three pins are asynchronous to the system clock. They are resynchronised, and the block acts on the rising edges of the serial clock that it sees in its own domain.

A frame starts when the load strobe falls. It carries a guard bit that must be zero, then a 3-bit register address sent least significant bit first, then one or more 12-bit words, also least significant bit first. Each complete word goes to a staging copy of the addressed register, and the address steps up by one after every word. When the strobe rises, all staged words move into the live registers in the same clock cycle. The live registers feed the rest of the chip through one flat output bus.

After reset, a lockout window of a programmable number of system clock cycles covers the time the analog side needs to calibrate. Any commit inside that window is dropped. Bit 0 of register 0 is a software reset: committing a 1 there returns every register to its default value.

Top module: `serial_reg_port`

## Requirements
- R1: Serial data is taken on each rising edge of the serial clock while the load strobe is low. The frame order is the guard bit, address bits A0 then A1 then A2, then data bits D0 through D11 of each word.
- R2: Words in one frame go to consecutive addresses, starting at the frame address and stepping up by one after each 12-bit word.
- R3: The live registers change only when the load strobe rises. The update appears on the third system clock edge after the strobe rises at the pin, and the registers hold their values for as long as the strobe stays low.
- R4: After reset, registers 0, 1 and 3 read 0x000 and register 2 reads 0x080 (decimal 128).
- R5: A committed word with bit D0 set in register 0 restores every register to its reset value, register 0 included.
- R6: For LOCK_CYCLES system clock cycles after reset, a strobe rise commits nothing. A frame that is rejected this way is discarded and is not applied once the window ends. Once the window ends, it stays ended until the next reset.
- R7: A frame whose guard bit is 1 changes no register.
- R8: If the strobe rises partway through a word, the words already completed in that frame are committed and the partial word is dropped.
- R9: Bits outside a register's defined width always read as 0. Register 2 keeps only D7..D0, register 3 keeps only D9..D0, and registers 0 and 1 keep all 12 bits.
- R10: A word addressed to a register index of NREG or above is dropped and does not affect any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous; data taken on its rising edge |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_load_i | input | 1 | Load strobe, low for a frame; commit on its rising edge |
| regs_o | output | NREG*12 | Live registers; register k occupies bits [12k+11:12k] |

## Verification
Every serial pin passes through two synchroniser flops and one edge-detect flop. A serial clock edge is therefore consumed on the third system clock edge after it reaches the pin, and a strobe rise reaches the registers on that same third edge. The bench holds each serial level for four system cycles and samples outputs on falling clock edges. In the commit-latency test it reads the registers once after two edges, when they must still hold the old values, and again after the third edge, when they must hold the new ones. All other results are read eight cycles after the strobe rises, well after the update has settled.

// File: rtl/srw_pkg.sv
// Shared constants and per-register tables for the serial register loader.
// Assumes a 12-bit word, a 3-bit address and a single guard bit per frame.
package srw_pkg;
    localparam int WORD_W   = 12;
    localparam int ADDR_W   = 3;
    localparam int HDR_BITS = 1 + ADDR_W;

    // Value a register takes on reset or on software reset.
    function automatic logic [WORD_W-1:0] reg_default(input int idx);
        return (idx == 2) ? WORD_W'(128) : '0;
    endfunction

    // Defined bits of each register; the rest always read as zero.
    function automatic logic [WORD_W-1:0] reg_mask(input int idx);
        case (idx)
            2:       return 12'h0FF;
            3:       return 12'h3FF;
            default: return 12'hFFF;
        endcase
    endfunction
endpackage

// File: rtl/srw_sync.sv
// Two-flop synchroniser plus one history flop for edge detection.
// Assumes each input is a slow level compared with clk.
module srw_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Move the pin levels into the clk domain and keep the prior value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/srw_lockout.sv
// Counts LOCK_CYCLES clocks after reset and reports the lockout window.
// Assumes the window opens only at reset.
module srw_lockout #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic locked_o
);
    localparam int CW = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt_q;

    // Run the counter up to the limit and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
    end

    assign locked_o = (cnt_q != LIMIT);

    AST_LOCK_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |=> !locked_o); // R6
endmodule

// File: rtl/srw_frame.sv
// Parses one serial frame (guard bit, address, words) into staging registers.
// Assumes bit_stb_i pulses for one clk per serial clock rise and bit_val_i
// is stable at that time; the frame state is cleared at each strobe fall.
module srw_frame
    import srw_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_stb_i,
    input  logic                   bit_val_i,
    input  logic                   load_low_i,
    input  logic                   load_fall_i,
    input  logic                   load_rise_i,
    output logic [NREG*WORD_W-1:0] stage_o,
    output logic [NREG-1:0]        pend_o,
    output logic                   commit_o
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int HDR_W = $clog2(HDR_BITS);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(WORD_W - 1);
    localparam logic [HDR_W-1:0] LAST_HDR = HDR_W'(HDR_BITS - 1);

    logic              in_hdr_q;
    logic [HDR_W-1:0]  hdr_cnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] shift_q;
    logic              bad_q;

    logic              take;
    logic              word_done;
    logic [WORD_W-1:0] word_full;

    assign take      = bit_stb_i & load_low_i;
    assign word_done = take & ~in_hdr_q & (bit_idx_q == LAST_BIT);
    assign word_full = {bit_val_i, shift_q[WORD_W-1:1]};

    // Walk the header and data bits, stepping the address per finished word.
    always_ff @(posedge clk) begin
        if (!rst_n || load_fall_i) begin
            in_hdr_q  <= 1'b1;
            hdr_cnt_q <= '0;
            bit_idx_q <= '0;
            addr_q    <= '0;
            shift_q   <= '0;
            bad_q     <= 1'b0;
        end else if (take) begin
            if (in_hdr_q) begin
                if (hdr_cnt_q == '0) bad_q <= bad_q | bit_val_i;
                else                 addr_q[hdr_cnt_q - HDR_W'(1)] <= bit_val_i;
                if (hdr_cnt_q == LAST_HDR) in_hdr_q <= 1'b0;
                hdr_cnt_q <= hdr_cnt_q + HDR_W'(1);
            end else begin
                shift_q <= word_full;
                if (bit_idx_q == LAST_BIT) begin
                    bit_idx_q <= '0;
                    addr_q    <= addr_q + ADDR_W'(1);
                end else begin
                    bit_idx_q <= bit_idx_q + IDX_W'(1);
                end
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_stage
        logic [WORD_W-1:0] stage_q;
        logic              pend_q;

        // Hold the last finished word for this address until the commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
                pend_q  <= 1'b0;
            end else if (load_fall_i) begin
                pend_q  <= 1'b0;
            end else if (word_done && addr_q == ADDR_W'(g)) begin
                stage_q <= word_full;
                pend_q  <= 1'b1;
            end
        end

        assign stage_o[g*WORD_W +: WORD_W] = stage_q;
        assign pend_o[g]                   = pend_q;
    end

    assign commit_o = load_rise_i & ~bad_q;

    AST_BIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx_q <= LAST_BIT); // R1
    AST_NO_DATA_IN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr_q |-> bit_idx_q == '0); // R1
endmodule

// File: rtl/srw_bank.sv
// Live register bank: commits staged words, applies masks and soft reset.
// Assumes commit_i is a single-cycle pulse and register 0 bit 0 is soft reset.
module srw_bank
    import srw_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_i,
    input  logic                   lock_i,
    input  logic [NREG*WORD_W-1:0] stage_i,
    input  logic [NREG-1:0]        pend_i,
    output logic [NREG*WORD_W-1:0] regs_o
);
    // Build the flat default and mask vectors from the package tables.
    function automatic logic [NREG*WORD_W-1:0] all_defaults();
        logic [NREG*WORD_W-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*WORD_W +: WORD_W] = reg_default(i);
        return v;
    endfunction

    function automatic logic [NREG*WORD_W-1:0] all_masks();
        logic [NREG*WORD_W-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*WORD_W +: WORD_W] = reg_mask(i);
        return v;
    endfunction

    localparam logic [NREG*WORD_W-1:0] DEFAULTS = all_defaults();
    localparam logic [NREG*WORD_W-1:0] MASKS    = all_masks();

    logic apply, soft_rst;

    assign apply    = commit_i & ~lock_i;
    assign soft_rst = apply & pend_i[0] & stage_i[0];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [WORD_W-1:0] live_q;

        // Load this register from staging on commit, or restore its default.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                live_q <= reg_default(g);
            else if (apply && pend_i[g])
                live_q <= stage_i[g*WORD_W +: WORD_W] & reg_mask(g);
        end

        assign regs_o[g*WORD_W +: WORD_W] = live_q;
    end

    AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(regs_o)); // R3
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(regs_o)); // R6
    AST_UNDEF_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o & ~MASKS) == '0); // R9
    AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !lock_i && pend_i[0] && stage_i[0]) |=> regs_o == DEFAULTS); // R5
endmodule

// File: rtl/serial_reg_port.sv
// Top of the serial register loader: synchroniser, frame parser,
// power-on lockout and live register bank.
// Assumes the serial pins change slowly compared with clk (each level
// held for at least three clk cycles).
module serial_reg_port
    import srw_pkg::*;
#(
    parameter int NREG        = 4,
    parameter int LOCK_CYCLES = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk_i,
    input  logic                   ser_data_i,
    input  logic                   ser_load_i,
    output logic [NREG*WORD_W-1:0] regs_o
);
    localparam int PIN_CLK  = 0;
    localparam int PIN_DATA = 1;
    localparam int PIN_LOAD = 2;

    logic [2:0]             pins_s, pins_p;
    logic                   bit_stb, load_low, load_fall, load_rise;
    logic                   commit, locked;
    logic [NREG*WORD_W-1:0] stage;
    logic [NREG-1:0]        pend;

    srw_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_load_i, ser_data_i, ser_clk_i}),
        .sync_o  (pins_s),
        .prev_o  (pins_p)
    );

    assign bit_stb   = pins_s[PIN_CLK] & ~pins_p[PIN_CLK];
    assign load_low  = ~pins_s[PIN_LOAD];
    assign load_fall = ~pins_s[PIN_LOAD] & pins_p[PIN_LOAD];
    assign load_rise = pins_s[PIN_LOAD] & ~pins_p[PIN_LOAD];

    srw_frame #(.NREG(NREG)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb_i   (bit_stb),
        .bit_val_i   (pins_s[PIN_DATA]),
        .load_low_i  (load_low),
        .load_fall_i (load_fall),
        .load_rise_i (load_rise),
        .stage_o     (stage),
        .pend_o      (pend),
        .commit_o    (commit)
    );

    srw_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked_o (locked)
    );

    srw_bank #(.NREG(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .lock_i   (locked),
        .stage_i  (stage),
        .pend_i   (pend),
        .regs_o   (regs_o)
    );

    AST_COMMIT_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> load_rise); // R3
endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
    localparam int NREG = 4;
    localparam int LOCK = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b1;
    logic [NREG*12-1:0] regs;

    int checks = 0;
    int fails  = 0;

    logic [11:0] model [NREG];
    logic [11:0] wbuf  [4];

    // {address, written word, expected register value}
    localparam logic [26:0] VEC [0:6] = '{
        {3'd3, 12'h2A5, 12'h2A5},
        {3'd2, 12'hFFF, 12'h0FF},
        {3'd1, 12'h07F, 12'h07F},
        {3'd0, 12'h04C, 12'h04C},
        {3'd3, 12'hC00, 12'h000},
        {3'd1, 12'hABC, 12'hABC},
        {3'd2, 12'h13C, 12'h03C}
    };

    always #2 clk = ~clk;

    serial_reg_port #(.NREG(NREG), .LOCK_CYCLES(LOCK)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_data_i (ser_data),
        .ser_load_i (ser_load),
        .regs_o     (regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        ser_data = b;
        tick(4);
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
    endtask

    task automatic frame(input logic guard, input logic [2:0] a, input int nw,
                         input int extra, input logic rise);
        ser_load = 1'b0;
        tick(4);
        put_bit(guard);
        for (int i = 0; i < 3; i++) put_bit(a[i]);
        for (int w = 0; w < nw; w++)
            for (int b = 0; b < 12; b++) put_bit(wbuf[w][b]);
        for (int e = 0; e < extra; e++) put_bit(1'b1);
        tick(4);
        if (rise) begin
            ser_load = 1'b1;
            tick(8);
        end
    endtask

    task automatic check_reg(input int k, input logic [11:0] exp, input string tag);
        logic [11:0] got;
        got = regs[k*12 +: 12];
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s reg%0d got %h expected %h", tag, k, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < NREG; k++) check_reg(k, model[k], tag);
    endtask

    task automatic set_defaults();
        for (int k = 0; k < NREG; k++) model[k] = (k == 2) ? 12'h080 : 12'h000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        set_defaults();
        tick(5);
        rst_n = 1'b1;
        tick(1);
        check_all("R4 reset values");

        // R6: frame inside the lockout window is dropped, and is not applied later
        wbuf[0] = 12'h155;
        frame(1'b0, 3'd3, 1, 0, 1'b1);
        check_all("R6 write during lockout");
        tick(LOCK + 100);
        check_all("R6 after lockout ends");

        // R1 / R9: single-word writes from the vector table
        for (int v = 0; v < 7; v++) begin
            wbuf[0] = VEC[v][23:12];
            frame(1'b0, VEC[v][26:24], 1, 0, 1'b1);
            model[VEC[v][26:24]] = VEC[v][11:0];
            check_reg(int'(VEC[v][26:24]), VEC[v][11:0], "R1 R9 vector");
        end
        check_all("R1 after vectors");

        // R3: no change while strobe low; update lands on the third edge
        wbuf[0] = 12'h008; wbuf[1] = 12'h011; wbuf[2] = 12'h0AA; wbuf[3] = 12'h123;
        frame(1'b0, 3'd0, 4, 0, 1'b0);
        tick(20);
        check_all("R3 strobe still low");
        ser_load = 1'b1;
        tick(2);
        check_all("R3 two edges after rise");
        tick(1);
        model[0] = 12'h008; model[1] = 12'h011; model[2] = 12'h0AA; model[3] = 12'h123;
        check_all("R2 R3 burst committed");
        tick(8);

        // R7: guard bit set discards the frame
        wbuf[0] = 12'h3FF;
        frame(1'b1, 3'd3, 1, 0, 1'b1);
        check_all("R7 guard bit set");

        // R8: strobe rises mid-word; finished word kept, partial dropped
        wbuf[0] = 12'h055;
        frame(1'b0, 3'd2, 1, 5, 1'b1);
        model[2] = 12'h055;
        check_all("R8 partial word");

        // R10: burst runs past the last register
        wbuf[0] = 12'h0F0; wbuf[1] = 12'hFFE;
        frame(1'b0, 3'd3, 2, 0, 1'b1);
        model[3] = 12'h0F0;
        check_all("R10 address past bank");

        // R5: software reset
        wbuf[0] = 12'h001;
        frame(1'b0, 3'd0, 1, 0, 1'b1);
        set_defaults();
        check_all("R5 soft reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule